// File: doc/BRIEF.md
# Interrupt Source Bank

This block stores the per-source state of a core-local interrupt controller with `N_SRC` sources. Software reaches it through a byte-wide register port (write strobe, byte address, write byte, combinational read byte). It samples the raw interrupt lines every clock and keeps one pending bit per source, set according to a trigger type chosen per source. Edge sources latch events until software or a claim from the core clears them. Level sources mirror their input.

The bank also holds a global configuration byte and a threshold byte. Its outputs are the pending, enable and control vectors plus the configuration and threshold bytes. A separate arbiter uses them to pick the winning interrupt. Claims arrive as a one-cycle strobe with a source number, and they drop the pending bit of an edge source that has been taken.

Top module: `isb_bank`

## Requirements
- R1: After reset every stored byte (configuration, threshold, and each source's pending, enable, attribute and control) is zero, and the pending vector is all zero.
- R2: The configuration byte at offset 0x0 and the threshold byte at offset 0xB are written with the whole write byte and read back unchanged. Their values also appear on `cfg_o` and `thr_o`.
- R3: Offsets 0x4 to 0x7 form a read-only information word that holds `CTL_BITS` starting at bit 21. With the default of 6, byte 0x6 reads 0xC0 and bytes 0x4, 0x5 and 0x7 read 0. Writes to these offsets change nothing.
- R4: Source `id` uses bytes 0x1000+4*id+k, where k=0 is pending, k=1 is enable, k=2 is attribute and k=3 is control. The enable byte keeps only bit 0 and reads as {7'b0, en}. The attribute and control bytes keep all 8 bits.
- R5: Attribute bits [2:1] select the trigger: 0 is level-high, 1 is rising edge, 3 is falling edge and 2 is reserved. A source set to the reserved code is never pending. Attribute bit 0 is stored only.
- R6: A level-high source's pending bit, after each clock edge, equals the input sampled at that edge.
- R7: A rising-edge source sets its pending bit at the first edge where the input is sampled high after being sampled low. The bit stays set after the input falls.
- R8: A falling-edge source sets its pending bit at the first edge where the input is sampled low after being sampled high. A rising input leaves the bit unchanged.
- R9: A write to a pending byte loads write bit 0 only when attribute bit 1 is set (edge modes). For level and reserved sources the write has no effect.
- R10: A claim strobe whose id names an edge-mode source clears that source's pending bit. A claim of a level source has no effect.
- R11: When a selected edge arrives in the same cycle as a claim, or as a software write of 0 to the pending byte, the pending bit ends up set.
- R12: Every other offset, including source ids at or above `N_SRC`, reads zero, and writes to it change no state.
- R13: `pend_o`, `en_o` and `ctl_o` (8 bits per source, source i at bits [8i+7:8i]) show the stored state of every source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | N_SRC | Raw interrupt lines, already synchronous |
| we_i | input | 1 | Byte write strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write byte |
| rdata_o | output | 8 | Read byte for `addr_i`, combinational |
| claim_vld_i | input | 1 | Claim strobe from the core |
| claim_id_i | input | ID_W | Source being claimed |
| pend_o | output | N_SRC | Pending vector |
| en_o | output | N_SRC | Enable vector |
| ctl_o | output | 8*N_SRC | Control bytes |
| cfg_o | output | 8 | Global configuration byte |
| thr_o | output | 8 | Threshold byte |

## Verification
The hardest case to reach is an edge event that falls in the same cycle as a claim or as a software clear of the same source. The stimulus first sets the pending bit by software while the line is low. In one cycle it then raises the line together with the claim strobe. After lowering the line, it raises it again in the same cycle as a write of 0 to the pending byte. Falling-edge and reserved trigger codes get their own sequences, where raising the line must leave the pending bit unchanged.

// File: rtl/isb_pkg.sv
package isb_pkg;

    localparam int unsigned CFG_OFS  = 'h0;
    localparam int unsigned INFO_OFS = 'h4;
    localparam int unsigned THR_OFS  = 'hB;
    localparam int unsigned SRC_BASE = 'h1000;

    typedef enum logic [1:0] {
        TRG_LEVEL = 2'd0,
        TRG_RISE  = 2'd1,
        TRG_RSVD  = 2'd2,
        TRG_FALL  = 2'd3
    } trig_e;

    typedef enum logic [1:0] {
        FLD_PEND = 2'd0,
        FLD_EN   = 2'd1,
        FLD_ATTR = 2'd2,
        FLD_CTL  = 2'd3
    } fld_e;

    typedef struct packed {
        logic       pend;
        logic       en;
        logic [7:0] attr;
        logic [7:0] ctl;
        logic       prev;
    } src_st_t;

    typedef struct packed {
        logic [7:0] cfg;
        logic [7:0] thr;
    } glb_st_t;

endpackage

// File: rtl/isb_decode.sv
module isb_decode
    import isb_pkg::*;
#(
    parameter int unsigned N_SRC  = 8,
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned ID_W   = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              hit_cfg_o,
    output logic              hit_thr_o,
    output logic              hit_info_o,
    output logic [1:0]        info_sel_o,
    output logic              hit_src_o,
    output logic [ID_W-1:0]   src_id_o,
    output fld_e              fld_o
);
    localparam int unsigned IDX_W = ADDR_W - 2;

    logic [ADDR_W-1:0] off;
    logic [IDX_W-1:0]  id_full;

    always_comb begin
        off        = addr_i - ADDR_W'(SRC_BASE);
        id_full    = off[ADDR_W-1:2];
        hit_cfg_o  = (addr_i == ADDR_W'(CFG_OFS));
        hit_thr_o  = (addr_i == ADDR_W'(THR_OFS));
        hit_info_o = (addr_i[ADDR_W-1:2] == IDX_W'(INFO_OFS >> 2));
        info_sel_o = addr_i[1:0];
        hit_src_o  = (addr_i >= ADDR_W'(SRC_BASE)) && (id_full < IDX_W'(N_SRC));
        src_id_o   = id_full[ID_W-1:0];
        fld_o      = fld_e'(addr_i[1:0]);
    end

endmodule

// File: rtl/isb_src.sv
module isb_src
    import isb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_i,
    input  logic       wr_i,
    input  fld_e       fld_i,
    input  logic [7:0] wdata_i,
    input  logic       claim_i,
    output logic       pend_o,
    output logic       en_o,
    output logic [7:0] attr_o,
    output logic [7:0] ctl_o
);
    src_st_t st_d, st_q;
    trig_e   trig;
    logic    rise, fall, edge_evt;

    always_comb begin
        st_d     = st_q;
        trig     = trig_e'(st_q.attr[2:1]);
        rise     = irq_i & ~st_q.prev;
        fall     = ~irq_i & st_q.prev;
        edge_evt = ((trig == TRG_RISE) && rise) || ((trig == TRG_FALL) && fall);
        st_d.prev = irq_i;

        if (wr_i) begin
            case (fld_i)
                FLD_PEND: if (st_q.attr[1]) st_d.pend = wdata_i[0];
                FLD_EN:   st_d.en   = wdata_i[0];
                FLD_ATTR: st_d.attr = wdata_i;
                FLD_CTL:  st_d.ctl  = wdata_i;
                default:  ;
            endcase
        end

        // claim removes only latched edge events
        if (claim_i && st_q.attr[1]) st_d.pend = 1'b0;

        // input events come last so a fresh edge is never lost
        case (trig)
            TRG_LEVEL: st_d.pend = irq_i;
            TRG_RISE:  if (rise) st_d.pend = 1'b1;
            TRG_FALL:  if (fall) st_d.pend = 1'b1;
            default:   st_d.pend = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;
    assign attr_o = st_q.attr;
    assign ctl_o  = st_q.ctl;

    a_r6_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.attr[2:1] == 2'd0) |=> (pend_o == $past(irq_i)));

    a_r7_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.attr[2:1] == 2'd1 && irq_i && !st_q.prev) |=> pend_o);

    a_r5_rsvd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.attr[2:1] == 2'd2) |=> !pend_o);

    a_r10_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.attr[1] && claim_i && !edge_evt) |=> !pend_o);

endmodule

// File: rtl/isb_bank.sv
module isb_bank
    import isb_pkg::*;
#(
    parameter int unsigned N_SRC    = 8,
    parameter int unsigned ADDR_W   = 13,
    parameter int unsigned CTL_BITS = 6,
    parameter int unsigned ID_W     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SRC-1:0]    irq_i,
    input  logic                we_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [7:0]          wdata_i,
    output logic [7:0]          rdata_o,
    input  logic                claim_vld_i,
    input  logic [ID_W-1:0]     claim_id_i,
    output logic [N_SRC-1:0]    pend_o,
    output logic [N_SRC-1:0]    en_o,
    output logic [N_SRC*8-1:0]  ctl_o,
    output logic [7:0]          cfg_o,
    output logic [7:0]          thr_o
);
    localparam logic [31:0] INFO_WORD = 32'(CTL_BITS) << 21;

    logic            hit_cfg, hit_thr, hit_info, hit_src;
    logic [1:0]      info_sel;
    logic [ID_W-1:0] src_id;
    fld_e            fld;

    logic [7:0] attr_a [N_SRC];
    logic [7:0] ctl_a  [N_SRC];

    glb_st_t glb_d, glb_q;

    isb_decode #(
        .N_SRC (N_SRC),
        .ADDR_W(ADDR_W),
        .ID_W  (ID_W)
    ) u_dec (
        .addr_i    (addr_i),
        .hit_cfg_o (hit_cfg),
        .hit_thr_o (hit_thr),
        .hit_info_o(hit_info),
        .info_sel_o(info_sel),
        .hit_src_o (hit_src),
        .src_id_o  (src_id),
        .fld_o     (fld)
    );

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        isb_src u_src (
            .clk    (clk),
            .rst_n  (rst_n),
            .irq_i  (irq_i[i]),
            .wr_i   (we_i && hit_src && (src_id == ID_W'(i))),
            .fld_i  (fld),
            .wdata_i(wdata_i),
            .claim_i(claim_vld_i && (claim_id_i == ID_W'(i))),
            .pend_o (pend_o[i]),
            .en_o   (en_o[i]),
            .attr_o (attr_a[i]),
            .ctl_o  (ctl_a[i])
        );
        assign ctl_o[i*8 +: 8] = ctl_a[i];
    end

    always_comb begin
        glb_d = glb_q;
        if (we_i && hit_cfg) glb_d.cfg = wdata_i;
        if (we_i && hit_thr) glb_d.thr = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) glb_q <= '0;
        else        glb_q <= glb_d;
    end

    assign cfg_o = glb_q.cfg;
    assign thr_o = glb_q.thr;

    always_comb begin
        rdata_o = 8'h00;
        if (hit_cfg) rdata_o = glb_q.cfg;
        if (hit_thr) rdata_o = glb_q.thr;
        if (hit_info) rdata_o = INFO_WORD[{info_sel, 3'b000} +: 8];
        if (hit_src) begin
            case (fld)
                FLD_PEND: rdata_o = {7'b0, pend_o[src_id]};
                FLD_EN:   rdata_o = {7'b0, en_o[src_id]};
                FLD_ATTR: rdata_o = attr_a[src_id];
                default:  rdata_o = ctl_a[src_id];
            endcase
        end
    end

    a_r2_cfg_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == ADDR_W'(CFG_OFS)) |=> (cfg_o == $past(wdata_i)));

    a_r2_thr_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == ADDR_W'(THR_OFS)) |=> (thr_o == $past(wdata_i)));

    a_r3_info_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == ADDR_W'(INFO_OFS + 2)) |-> (rdata_o == 8'(CTL_BITS << 5)));

endmodule

// File: tb/sim_isb_bank.sv
`timescale 1ns/1ps
module sim_isb_bank;
    localparam int N  = 8;
    localparam int AW = 13;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq = '0;
    logic          we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    wdata = '0;
    logic [7:0]    rdata;
    logic          claim_vld = 1'b0;
    logic [IW-1:0] claim_id = '0;
    logic [N-1:0]  pend, en;
    logic [N*8-1:0] ctl;
    logic [7:0]    cfg, thr;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;   // 0 rdata, 1 pend_o, 2 en_o, 3 ctl_o byte of source addr
        logic [AW-1:0] a;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;

    isb_bank #(.N_SRC(N), .ADDR_W(AW), .CTL_BITS(6)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_i(irq), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .claim_vld_i(claim_vld),
        .claim_id_i(claim_id), .pend_o(pend), .en_o(en), .ctl_o(ctl),
        .cfg_o(cfg), .thr_o(thr)
    );

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d; claim_vld = 1'b0;
    endtask

    task automatic set_irq(input int idx, input logic v);
        @(negedge clk);
        we = 1'b0; claim_vld = 1'b0; irq[idx] = v;
    endtask

    task automatic claim(input int id);
        @(negedge clk);
        we = 1'b0; claim_vld = 1'b1; claim_id = IW'(id);
    endtask

    task automatic chk(input int kind, input logic [AW-1:0] a,
                       input logic [31:0] exp, input string req);
        item_t it;
        @(negedge clk);
        we = 1'b0; claim_vld = 1'b0; addr = a;
        it.kind = kind; it.a = a; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    // monitor: compares one queued item per cycle, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0: act = 32'(rdata);
                    1: act = 32'(pend);
                    2: act = 32'(en);
                    default: act = 32'((ctl >> (it.a * 8)) & 64'hFF);
                endcase
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s kind=%0d addr=%h actual=%h expected=%h",
                             it.req, it.kind, it.a, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk(1, 0, 32'h00, "R1");
        chk(0, 13'h0000, 32'h00, "R1");
        chk(0, 13'h000B, 32'h00, "R1");
        chk(0, 13'h101F, 32'h00, "R1");
        chk(0, 13'h1009, 32'h00, "R1");

        // R2 config and threshold
        wr(13'h0000, 8'hA5);
        chk(0, 13'h0000, 32'hA5, "R2");
        wr(13'h000B, 8'h3C);
        chk(0, 13'h000B, 32'h3C, "R2");

        // R3 info word
        chk(0, 13'h0006, 32'hC0, "R3");
        chk(0, 13'h0004, 32'h00, "R3");
        wr(13'h0006, 8'hFF);
        chk(0, 13'h0006, 32'hC0, "R3");
        chk(0, 13'h0000, 32'hA5, "R3");

        // R4 per-source layout, R13 vectors
        wr(13'h1009, 8'hFF);
        chk(0, 13'h1009, 32'h01, "R4");
        chk(2, 0, 32'h04, "R13");
        wr(13'h1016, 8'h07);
        chk(0, 13'h1016, 32'h07, "R4");
        wr(13'h101F, 8'h9E);
        chk(0, 13'h101F, 32'h9E, "R4");
        chk(3, 13'd7, 32'h9E, "R13");
        wr(13'h1006, 8'h02);
        chk(0, 13'h1006, 32'h02, "R4");
        wr(13'h100E, 8'h04);

        // R12 unmapped
        wr(13'h1020, 8'h55);
        chk(0, 13'h1020, 32'h00, "R12");
        chk(0, 13'h0008, 32'h00, "R12");
        wr(13'h0001, 8'h77);
        chk(0, 13'h0001, 32'h00, "R12");
        chk(0, 13'h0000, 32'hA5, "R12");

        // R6 level on source 0
        set_irq(0, 1'b1);
        chk(1, 0, 32'h01, "R6");
        chk(0, 13'h1000, 32'h01, "R6");
        claim(0);
        chk(1, 0, 32'h01, "R10");
        set_irq(0, 1'b0);
        chk(1, 0, 32'h00, "R6");
        wr(13'h1000, 8'h01);
        chk(1, 0, 32'h00, "R9");

        // R7 rising edge on source 1
        set_irq(1, 1'b1);
        chk(1, 0, 32'h02, "R7");
        set_irq(1, 1'b0);
        chk(1, 0, 32'h02, "R7");
        claim(1);
        chk(1, 0, 32'h00, "R10");

        // R8 falling edge on source 5
        set_irq(5, 1'b1);
        chk(1, 0, 32'h00, "R8");
        set_irq(5, 1'b0);
        chk(1, 0, 32'h20, "R8");
        wr(13'h1014, 8'h00);
        chk(1, 0, 32'h00, "R9");
        wr(13'h1014, 8'h01);
        chk(1, 0, 32'h20, "R9");
        claim(5);
        chk(1, 0, 32'h00, "R10");

        // R5 reserved trigger on source 3
        set_irq(3, 1'b1);
        chk(1, 0, 32'h00, "R5");
        wr(13'h100C, 8'h01);
        chk(1, 0, 32'h00, "R5");
        set_irq(3, 1'b0);

        // R11 same-cycle collisions on source 1
        wr(13'h1004, 8'h01);
        chk(1, 0, 32'h02, "R9");
        @(negedge clk);
        we = 1'b0; claim_vld = 1'b1; claim_id = 3'd1; irq[1] = 1'b1;
        chk(1, 0, 32'h02, "R11");
        set_irq(1, 1'b0);
        chk(1, 0, 32'h02, "R11");
        @(negedge clk);
        we = 1'b1; addr = 13'h1004; wdata = 8'h00; claim_vld = 1'b0; irq[1] = 1'b1;
        chk(1, 0, 32'h02, "R11");
        claim(1);
        chk(1, 0, 32'h00, "R10");
        chk(0, 13'h1004, 32'h00, "R4");

        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule